// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block drives the two low-side switches of a synchronous flyback converter running in valley-switching (quasi-resonant) mode. A primary interval ends on a peak-current trip, a guarded dead time follows, and then the secondary switch conducts. The secondary interval ends when the digitised desaturation comparator falls, because that edge marks the point where the transformer has run out of energy. After a second dead time, the primary switch turns on again and the next cycle begins. Switching periods therefore follow the magnetics rather than a fixed clock.

At primary turn-off the block starts a blanking one-shot. While this pulse is high, comparator edges caused by switching ringing are masked, the edge-capture flip-flop is cleared and a watchdog timer is restarted. The same pulse leaves the block as a strobe. A qualified desaturation fall sets the flip-flop and fires a short trigger one-shot, and that trigger ends the secondary interval. If no valid edge arrives before the watchdog period runs out, and the watchdog is enabled, the watchdog forces a new cycle. The watchdog also launches the very first cycle after reset. When valley mode is off, the comparator path is ignored and the watchdog alone paces the converter.

Top module: `qr_cycle_seq`

## Requirements
- R1: While reset is held, and after its release until the first enabled watchdog expiry, both drives and the strobe are low.
- R2: The watchdog expires `wd_period` cycles after it restarts. It restarts on reset release, on the first cycle after the blanking pulse ends, and after each expiry. An expiry with `wd_en`=1 in the idle or secondary state turns the secondary drive off on the next edge and begins the primary dead time.
- R3: `ipk_trip` sampled high while the primary drive is on makes the primary drive low on the next cycle. A trip in any other state has no effect.
- R4: Between one drive falling and the other rising, both drives stay low for max(dt,1) cycles. The value dt is `dt_sec` before the secondary turns on and `dt_pri` before the primary turns on.
- R5: `wd_rst_strobe` rises in the same cycle the primary drive falls and stays high for exactly BLANK_CYC cycles (default 24).
- R6: The desaturation input passes through two synchroniser flops. A high-to-low change that is qualified turns the secondary drive off on the fourth rising edge, counting the first edge that samples the low level as the first. A fall is qualified when valley mode is on, the secondary drive is on and blanking is inactive.
- R7: A desaturation fall that reaches the edge detector while the blanking pulse is high does not end the secondary interval, and rising edges never do.
- R8: With `qr_en`=0, desaturation edges have no effect and the secondary interval ends only on a watchdog expiry.
- R9: With `wd_en`=0, a watchdog expiry has no effect on the drives.
- R10: The primary and secondary drives are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desat_in | input | 1 | Asynchronous desaturation comparator output |
| ipk_trip | input | 1 | Peak-current comparator trip |
| qr_en | input | 1 | Valley-switching mode enable |
| wd_en | input | 1 | Watchdog restart enable |
| wd_period | input | WD_W (16) | Watchdog expiry count in cycles |
| dt_pri | input | DT_W (6) | Dead time before primary turn-on |
| dt_sec | input | DT_W (6) | Dead time before secondary turn-on |
| pri_drv | output | 1 | Primary switch gate command |
| sec_drv | output | 1 | Secondary switch gate command |
| wd_rst_strobe | output | 1 | Blanking pulse, also the watchdog restart |

## Verification
Each stimulus has a known delay to its result:
- A trip lowers the primary drive and raises the strobe one edge later.
- The secondary drive follows `dt_sec` cycles after that, and the strobe falls BLANK_CYC cycles after it rose.
- A desaturation fall ends the secondary interval four edges after the edge that samples it.
- A watchdog restart ends the secondary interval `wd_period`+1 cycles after blanking ends.

The driver computes these cycle numbers from its own drive times and queues the expected output vectors. The monitor compares every change of the three outputs against the head of that queue, matching both the value and the cycle count. Any change that the queue does not predict fails, so a trip, edge or expiry that should have been ignored is caught as an unexpected edge.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_PRI    = 3'd1,
        SQ_DT_SEC = 3'd2,
        SQ_SEC    = 3'd3,
        SQ_DT_PRI = 3'd4
    } sq_state_e;

endpackage

// File: rtl/qr_desat_sync.sv
module qr_desat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.sh   = {sy_q.sh[STAGES-2:0], din};
        sy_d.last = sy_q.sh[STAGES-1];
        fall      = sy_q.last & ~sy_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end
endmodule

// File: rtl/qr_oneshot.sv
module qr_oneshot #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } os_t;

    os_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        if (fire) begin
            os_d.act = 1'b1;
            os_d.cnt = CW'(WIDTH - 1);
        end else if (os_q.act) begin
            if (os_q.cnt == '0) os_d.act = 1'b0;
            else                os_d.cnt = os_q.cnt - 1'b1;
        end
        pulse = os_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end
endmodule

// File: rtl/qr_wdog.sv
module qr_wdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] period,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d   = wd_q;
        expire = (wd_q.cnt == period) && !clr;
        if (clr || expire) wd_d.cnt = '0;
        else               wd_d.cnt = wd_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
    import qr_seq_pkg::*;
#(
    parameter int BLANK_CYC   = 24,
    parameter int TRIG_CYC    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WD_W        = 16,
    parameter int DT_W        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            desat_in,
    input  logic            ipk_trip,
    input  logic            qr_en,
    input  logic            wd_en,
    input  logic [WD_W-1:0] wd_period,
    input  logic [DT_W-1:0] dt_pri,
    input  logic [DT_W-1:0] dt_sec,
    output logic            pri_drv,
    output logic            sec_drv,
    output logic            wd_rst_strobe
);
    localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

    typedef struct packed {
        sq_state_e       state;
        logic [DT_W-1:0] dt_cnt;
        logic            sync_ff;
    } seq_t;

    seq_t st_d, st_q;

    logic desat_fall;
    logic blank_pulse;
    logic trig_pulse;
    logic wd_exp;
    logic blank_fire;
    logic trig_fire;
    logic restart;

    qr_desat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (desat_in),
        .fall  (desat_fall)
    );

    qr_oneshot #(.WIDTH(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (blank_fire),
        .pulse (blank_pulse)
    );

    qr_oneshot #(.WIDTH(TRIG_CYC)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (trig_fire),
        .pulse (trig_pulse)
    );

    qr_wdog #(.W(WD_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (blank_pulse),
        .period (wd_period),
        .expire (wd_exp)
    );

    always_comb begin
        st_d       = st_q;
        restart    = wd_exp && wd_en;
        blank_fire = (st_q.state == SQ_PRI) && ipk_trip;
        trig_fire  = desat_fall && qr_en && (st_q.state == SQ_SEC)
                     && !blank_pulse && !st_q.sync_ff;

        // capture flip-flop: cleared by blanking, set by a qualified edge
        if (blank_pulse)    st_d.sync_ff = 1'b0;
        else if (trig_fire) st_d.sync_ff = 1'b1;

        unique case (st_q.state)
            SQ_IDLE: begin
                if (restart) begin
                    st_d.state  = SQ_DT_PRI;
                    st_d.dt_cnt = DT_ONE;
                end
            end
            SQ_PRI: begin
                if (ipk_trip) begin
                    st_d.state  = SQ_DT_SEC;
                    st_d.dt_cnt = DT_ONE;
                end
            end
            SQ_DT_SEC: begin
                if (st_q.dt_cnt >= dt_sec) st_d.state  = SQ_SEC;
                else                       st_d.dt_cnt = st_q.dt_cnt + 1'b1;
            end
            SQ_SEC: begin
                if (trig_pulse || restart) begin
                    st_d.state  = SQ_DT_PRI;
                    st_d.dt_cnt = DT_ONE;
                end
            end
            SQ_DT_PRI: begin
                if (st_q.dt_cnt >= dt_pri) st_d.state  = SQ_PRI;
                else                       st_d.dt_cnt = st_q.dt_cnt + 1'b1;
            end
            default: begin
                st_d.state  = SQ_IDLE;
                st_d.dt_cnt = '0;
            end
        endcase

        pri_drv       = (st_q.state == SQ_PRI);
        sec_drv       = (st_q.state == SQ_SEC);
        wd_rst_strobe = blank_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state   <= SQ_IDLE;
            st_q.dt_cnt  <= '0;
            st_q.sync_ff <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/qr_cycle_seq_chk.sv
module qr_cycle_seq_chk #(
    parameter int BLANK_CYC = 24
) (
    input logic clk,
    input logic rst_n,
    input logic ipk_trip,
    input logic wd_en,
    input logic pri_drv,
    input logic sec_drv,
    input logic wd_rst_strobe,
    input logic trig_pulse,
    input logic wd_exp
);
    logic        started_q;
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            run_q     <= '0;
        end else begin
            if (wd_exp && wd_en) started_q <= 1'b1;
            if (wd_rst_strobe) run_q <= run_q + 1'b1;
            else               run_q <= '0;
        end
    end

    // R1: no drive before the first enabled expiry
    assert_idle_until_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_drv || sec_drv) |-> started_q);

    assert_trip_ends_primary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_drv && ipk_trip) |=> !pri_drv);

    assert_dead_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_drv) |-> !$past(pri_drv));

    assert_strobe_at_turnoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pri_drv) |-> $rose(wd_rst_strobe));

    assert_strobe_max_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_strobe |-> (run_q < 16'(BLANK_CYC)));

    assert_strobe_full_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_strobe) |-> ($past(run_q) == 16'(BLANK_CYC - 1)));

    assert_no_wd_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_drv && !wd_en && !trig_pulse) |=> sec_drv);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_drv && sec_drv));
endmodule

bind qr_cycle_seq qr_cycle_seq_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ipk_trip      (ipk_trip),
    .wd_en         (wd_en),
    .pri_drv       (pri_drv),
    .sec_drv       (sec_drv),
    .wd_rst_strobe (wd_rst_strobe),
    .trig_pulse    (trig_pulse),
    .wd_exp        (wd_exp)
);

// File: tb/sim_qr_cycle_seq.sv
module sim_qr_cycle_seq;
    localparam int BLANK = 24;
    localparam int P     = 40;
    localparam int DTP   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desat_in = 1'b1;
    logic        ipk_trip = 1'b0;
    logic        qr_en = 1'b1;
    logic        wd_en = 1'b1;
    logic [15:0] wd_period = 16'(P);
    logic [5:0]  dt_pri = 6'(DTP);
    logic [5:0]  dt_sec = 6'd3;
    logic        pri_drv, sec_drv, wd_rst_strobe;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int          exp_c[$];
    logic [2:0]  exp_v[$];
    string       exp_r[$];
    logic [2:0]  prev = 3'b000;
    logic [2:0]  cur;

    qr_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .desat_in(desat_in), .ipk_trip(ipk_trip),
        .qr_en(qr_en), .wd_en(wd_en), .wd_period(wd_period),
        .dt_pri(dt_pri), .dt_sec(dt_sec),
        .pri_drv(pri_drv), .sec_drv(sec_drv), .wd_rst_strobe(wd_rst_strobe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push_exp(int c, logic [2:0] v, string req);
        exp_c.push_back(c);
        exp_v.push_back(v);
        exp_r.push_back(req);
    endtask

    task automatic go_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_idle(string req);
        checks++;
        if ({pri_drv, sec_drv, wd_rst_strobe} !== 3'b000) begin
            fails++;
            $display("FAIL %s idle outputs: actual %b expected 000 at cycle %0d",
                     req, {pri_drv, sec_drv, wd_rst_strobe}, cyc);
        end
    endtask

    // monitor: every output change must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cur = {pri_drv, sec_drv, wd_rst_strobe};
            if (cur !== prev) begin
                checks++;
                if (pri_drv && sec_drv) begin
                    fails++;
                    $display("FAIL R10 overlap: actual %b expected not 11x at cycle %0d", cur, cyc);
                end
                checks++;
                if (exp_c.size() == 0) begin
                    fails++;
                    $display("FAIL R3 R7 R8 R9 unsolicited change: actual %b at cycle %0d, expected no change",
                             cur, cyc);
                end else begin
                    automatic int         ec = exp_c.pop_front();
                    automatic logic [2:0] ev = exp_v.pop_front();
                    automatic string      er = exp_r.pop_front();
                    if (ec != cyc || ev !== cur) begin
                        fails++;
                        $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                                 er, cur, cyc, ev, ec);
                    end
                end
            end
            prev = cur;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int r, t0, n, m, p1, n2, m2, p2, n3, p3, n4, b4;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        r = cyc;
        // R2: first expiry at r+P, dead time DTP, then primary on
        push_exp(r + P + 1 + DTP, 3'b100, "R2");
        go_to(r + 20);
        check_idle("R1");
        t0 = r + P + 1 + DTP;

        // cycle 1: normal valley switching, dt_sec = 3
        n = t0 + 5;
        go_to(n); ipk_trip = 1'b1;
        push_exp(n + 1, 3'b001, "R3");
        push_exp(n + 4, 3'b011, "R4");
        push_exp(n + 1 + BLANK, 3'b010, "R5");
        go_to(n + 1); ipk_trip = 1'b0;
        m = n + 30;
        go_to(m); desat_in = 1'b0;
        push_exp(m + 4, 3'b000, "R6");
        push_exp(m + 4 + DTP, 3'b100, "R4");
        go_to(m + 6); desat_in = 1'b1;
        p1 = m + 6;

        // cycle 2: zero dead time, fall masked by blanking
        dt_sec = 6'd0;
        n2 = p1 + 3;
        go_to(n2); ipk_trip = 1'b1;
        push_exp(n2 + 1, 3'b001, "R3");
        push_exp(n2 + 2, 3'b011, "R4");
        push_exp(n2 + 1 + BLANK, 3'b010, "R5");
        go_to(n2 + 1); ipk_trip = 1'b0;
        go_to(n2 + 8); desat_in = 1'b0;
        go_to(n2 + 20); desat_in = 1'b1;
        m2 = n2 + 30;
        go_to(m2); desat_in = 1'b0;
        push_exp(m2 + 4, 3'b000, "R7");
        push_exp(m2 + 4 + DTP, 3'b100, "R4");
        go_to(m2 + 6); desat_in = 1'b1;
        dt_sec = 6'd3;
        p2 = m2 + 6;

        // cycle 3: valley mode off, trip in secondary ignored, watchdog ends it
        n3 = p2 + 2;
        go_to(n3); ipk_trip = 1'b1;
        push_exp(n3 + 1, 3'b001, "R3");
        push_exp(n3 + 4, 3'b011, "R4");
        push_exp(n3 + 1 + BLANK, 3'b010, "R5");
        go_to(n3 + 1); ipk_trip = 1'b0;
        go_to(n3 + 10); qr_en = 1'b0;
        go_to(n3 + 12); ipk_trip = 1'b1;
        go_to(n3 + 13); ipk_trip = 1'b0;
        go_to(n3 + 30); desat_in = 1'b0;
        push_exp(n3 + 1 + BLANK + P + 1, 3'b000, "R8");
        push_exp(n3 + 1 + BLANK + P + 1 + DTP, 3'b100, "R4");
        go_to(n3 + 40); desat_in = 1'b1;
        p3 = n3 + 1 + BLANK + P + 1 + DTP;
        go_to(p3); qr_en = 1'b1;

        // cycle 4: watchdog disabled over three expiries, then re-enabled
        wd_en = 1'b0;
        n4 = p3 + 2;
        go_to(n4); ipk_trip = 1'b1;
        push_exp(n4 + 1, 3'b001, "R3");
        push_exp(n4 + 4, 3'b011, "R4");
        push_exp(n4 + 1 + BLANK, 3'b010, "R5");
        go_to(n4 + 1); ipk_trip = 1'b0;
        b4 = n4 + 1 + BLANK;
        go_to(b4 + 3 * P + 10); wd_en = 1'b1;
        push_exp(b4 + 4 * P + 4, 3'b000, "R9");
        push_exp(b4 + 4 * P + 4 + DTP, 3'b100, "R4");
        go_to(b4 + 4 * P + 16);

        checks++;
        if (exp_c.size() != 0) begin
            fails++;
            $display("FAIL R2 pending items: actual %0d left, expected 0", exp_c.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule